// File: doc/BRIEF.md
# Multiply, Divide and Accumulate Coprocessor

This block sits beside a 16-bit processor. It works on a single 32-bit result register. A mode byte, written by the processor, chooses one of three kinds of action. It can preset the register, in three ways. It can run one signed multiply-accumulate step or one unsigned 16-by-16 division each time an argument pair is written with a result expected. It can also simply read the register back. A separate bit of the mode byte chooses which half of the register drives the 16-bit result output. A flag output reports accumulate overflow or division by zero.

There are three write strobes on the processor side:
- `mode_we` loads the mode byte.
- `calc_we` hands over an argument pair and expects an answer. It is acknowledged by a one-cycle `done`.
- `load_we` hands over preset data and returns nothing.

Multiply-accumulate completes in one cycle. Division runs a restoring loop of 16 steps, and `busy` stays high while it runs. A small state machine sequences the work:
- In `ST_IDLE`, the block accepts writes.
- In `ST_DIVIDE`, the division loop runs.
- In `ST_REPLY`, the block presents `done`.

The transitions are:
- IDLE→DIVIDE: `calc_we` in division mode.
- IDLE→REPLY: `calc_we` in any other mode.
- DIVIDE→REPLY: the loop has finished.
- REPLY→IDLE: always.

Top module: `muldiv_copro`

## Requirements
- R1: After reset the result register, flag and stored mode are zero, so `res_out`=0, `flag_out`=0, `busy`=0 and `done`=0.
- R2: The block accepts a mode write only in ST_IDLE (`busy`=0). Bits [3:0] give the operation and bit 4 selects the output half. Bits [7:5] are ignored. When `mode_we` coincides with `calc_we` or `load_we`, only the mode write takes effect.
- R3: Operation 0x0 clears the result register and the flag at the edge that accepts the mode write, with no argument transfer.
- R4: In operation 0x1, the next idle `load_we` loads `arg1` sign-extended to 32 bits. In operation 0x2, it loads {`arg1`,`arg2`}, with `arg1` as the high half. In any other operation, `load_we` changes nothing and produces no `done`.
- R5: In operation 0x7, each accepted `calc_we` sets the register to register + signed(`arg1`)×signed(`arg2`), modulo 2^32. `done` is high in the first cycle after the accepting edge.
- R6: A multiply-accumulate step whose signed 32-bit sum overflows sets the flag. The flag then stays set across later steps until a mode write of operation 0x0, 0x1 or 0x2 clears it.
- R7: In operation 0x8, an accepted `calc_we` divides `arg1` by `arg2`, both unsigned. The quotient goes to bits [15:0], the remainder to bits [31:16], and the flag is cleared. `done` appears in the 18th cycle after the accepting edge.
- R8: Division by zero gives quotient 0xFFFF, gives remainder equal to the dividend, and sets the flag.
- R9: In operation 0x3 (read) and in the undefined operations, an accepted `calc_we` leaves the register and flag unchanged and still returns `done` in the next cycle.
- R10: `res_out` shows register bits [15:0] when half select is 0 and bits [31:16] when it is 1. `flag_out` always shows the flag.
- R11: `busy` is high from the cycle after an accepted `calc_we` through the cycle in which `done` is high. `done` lasts one cycle. Mode, calc and load writes made while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we | input | 1 | Mode byte write strobe |
| mode_data | input | 8 | Mode byte: [3:0] operation, [4] half select |
| calc_we | input | 1 | Argument write that expects a result |
| load_we | input | 1 | Argument write with no result (presets) |
| arg1 | input | 16 | First argument (multiplicand, dividend, preset data or preset high half) |
| arg2 | input | 16 | Second argument (multiplier, divisor, or preset low half) |
| res_out | output | 16 | Selected half of the result register |
| flag_out | output | 1 | Overflow or divide-by-zero flag |
| busy | output | 1 | Operation in progress; writes ignored |
| done | output | 1 | One-cycle completion pulse for `calc_we` |

## Verification
A corrupted result register shows on `res_out` in the first cycle after the faulty edge, but only for the half currently selected. The bench therefore reads both halves back with read-mode writes after presets, sequences and divisions, so a fault in the hidden half appears within a few cycles. A wrong state transition shows as `done` in the wrong cycle: one cycle after acceptance for accumulate and read, 18 for division. The bench measures that distance on every operation. Flag corruption shows directly on `flag_out`, and the bench compares it after every step against a model that carries stickiness and clearing.

// File: rtl/copro_pkg.sv
package copro_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIVIDE,
        ST_REPLY
    } cp_state_e;

    typedef enum logic [2:0] {
        AOP_HOLD,
        AOP_CLEAR,
        AOP_FLAGCLR,
        AOP_LOAD16,
        AOP_LOAD32,
        AOP_MAC,
        AOP_DIVRES
    } acc_op_e;

    localparam logic [3:0] OP_INIT0 = 4'h0;
    localparam logic [3:0] OP_INIT1 = 4'h1;
    localparam logic [3:0] OP_INIT2 = 4'h2;
    localparam logic [3:0] OP_READ  = 4'h3;
    localparam logic [3:0] OP_MAC   = 4'h7;
    localparam logic [3:0] OP_DIV   = 4'h8;

    typedef struct packed {
        logic       half;
        logic [3:0] op;
    } mode_t;

endpackage

// File: rtl/copro_ctrl.sv
module copro_ctrl
    import copro_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_we,
    input  logic [4:0] mode_bits,
    input  logic       calc_we,
    input  logic       load_we,
    input  logic       div_fin,
    output mode_t      mode_q,
    output acc_op_e    acc_op,
    output logic       div_start,
    output logic       busy,
    output logic       done
);

    cp_state_e state_q;
    cp_state_e state_d;
    logic      accept;

    assign accept = (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // mode register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (accept && mode_we) begin
            mode_q <= mode_t'(mode_bits);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!mode_we && calc_we) begin
                    state_d = (mode_q.op == OP_DIV) ? ST_DIVIDE : ST_REPLY;
                end
            end
            ST_DIVIDE: begin
                if (div_fin) begin
                    state_d = ST_REPLY;
                end
            end
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        acc_op    = AOP_HOLD;
        div_start = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (mode_we) begin
                    case (mode_bits[3:0])
                        OP_INIT0:          acc_op = AOP_CLEAR;
                        OP_INIT1, OP_INIT2: acc_op = AOP_FLAGCLR;
                        default:           acc_op = AOP_HOLD;
                    endcase
                end else if (calc_we) begin
                    if (mode_q.op == OP_MAC) begin
                        acc_op = AOP_MAC;
                    end else if (mode_q.op == OP_DIV) begin
                        div_start = 1'b1;
                    end
                end else if (load_we) begin
                    if (mode_q.op == OP_INIT1) begin
                        acc_op = AOP_LOAD16;
                    end else if (mode_q.op == OP_INIT2) begin
                        acc_op = AOP_LOAD32;
                    end
                end
            end
            ST_DIVIDE: begin
                if (div_fin) begin
                    acc_op = AOP_DIVRES;
                end
            end
            ST_REPLY: acc_op = AOP_HOLD;
            default:  acc_op = AOP_HOLD;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_REPLY);

endmodule

// File: rtl/copro_div.sv
module copro_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         fin,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         zero
);

    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  dsr_q;
    logic          zero_q;
    logic [W:0]    trial;
    logic          fits;

    // shift next dividend bit into the partial remainder
    assign trial = {rem_q, quo_q[W-1]};
    assign fits  = (trial >= {1'b0, dsr_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
            dsr_q  <= '0;
            zero_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= CW'(W);
            quo_q  <= dividend;
            rem_q  <= '0;
            dsr_q  <= divisor;
            zero_q <= (divisor == '0);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            quo_q <= {quo_q[W-2:0], fits};
            if (fits) begin
                rem_q <= W'(trial - {1'b0, dsr_q});
            end else begin
                rem_q <= trial[W-1:0];
            end
        end
    end

    assign fin  = (cnt_q == '0);
    assign quo  = quo_q;
    assign rem  = rem_q;
    assign zero = zero_q;

endmodule

// File: rtl/copro_accum.sv
module copro_accum
    import copro_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  acc_op_e        acc_op,
    input  logic [W-1:0]   arg1,
    input  logic [W-1:0]   arg2,
    input  logic [W-1:0]   div_quo,
    input  logic [W-1:0]   div_rem,
    input  logic           div_zero,
    output logic [2*W-1:0] acc,
    output logic           flag
);

    localparam int AW = 2 * W;

    logic [AW-1:0]        acc_q;
    logic                 flag_q;
    logic signed [AW-1:0] prod;
    logic [AW-1:0]        sum;
    logic                 ovf;

    assign prod = $signed(arg1) * $signed(arg2);
    assign sum  = acc_q + prod;
    assign ovf  = (acc_q[AW-1] == prod[AW-1]) && (sum[AW-1] != acc_q[AW-1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            unique case (acc_op)
                AOP_HOLD: ;
                AOP_CLEAR: begin
                    acc_q  <= '0;
                    flag_q <= 1'b0;
                end
                AOP_FLAGCLR: flag_q <= 1'b0;
                AOP_LOAD16:  acc_q  <= {{W{arg1[W-1]}}, arg1};
                AOP_LOAD32:  acc_q  <= {arg1, arg2};
                AOP_MAC: begin
                    acc_q  <= sum;
                    flag_q <= flag_q | ovf;
                end
                AOP_DIVRES: begin
                    acc_q  <= {div_rem, div_quo};
                    flag_q <= div_zero;
                end
                default: ;
            endcase
        end
    end

    assign acc  = acc_q;
    assign flag = flag_q;

endmodule

// File: rtl/copro_outsel.sv
module copro_outsel #(
    parameter int W = 16
) (
    input  logic           half,
    input  logic [2*W-1:0] acc,
    output logic [W-1:0]   res
);

    assign res = half ? acc[2*W-1:W] : acc[W-1:0];

endmodule

// File: rtl/muldiv_copro.sv
module muldiv_copro
    import copro_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_we,
    input  logic [7:0]   mode_data,
    input  logic         calc_we,
    input  logic         load_we,
    input  logic [W-1:0] arg1,
    input  logic [W-1:0] arg2,
    output logic [W-1:0] res_out,
    output logic         flag_out,
    output logic         busy,
    output logic         done
);

    mode_t          mode_q;
    acc_op_e        acc_op;
    logic           div_start;
    logic           div_fin;
    logic           div_zero;
    logic [W-1:0]   div_quo;
    logic [W-1:0]   div_rem;
    logic [2*W-1:0] acc;

    copro_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_we   (mode_we),
        .mode_bits (mode_data[4:0]),
        .calc_we   (calc_we),
        .load_we   (load_we),
        .div_fin   (div_fin),
        .mode_q    (mode_q),
        .acc_op    (acc_op),
        .div_start (div_start),
        .busy      (busy),
        .done      (done)
    );

    copro_div #(.W(W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (arg1),
        .divisor  (arg2),
        .fin      (div_fin),
        .quo      (div_quo),
        .rem      (div_rem),
        .zero     (div_zero)
    );

    copro_accum #(.W(W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_op   (acc_op),
        .arg1     (arg1),
        .arg2     (arg2),
        .div_quo  (div_quo),
        .div_rem  (div_rem),
        .div_zero (div_zero),
        .acc      (acc),
        .flag     (flag_out)
    );

    copro_outsel #(.W(W)) u_sel (
        .half (mode_q.half),
        .acc  (acc),
        .res  (res_out)
    );

endmodule

// File: rtl/copro_chk.sv
module copro_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mode_we,
    input logic [7:0]   mode_data,
    input logic         calc_we,
    input logic         load_we,
    input logic [W-1:0] res_out,
    input logic         flag_out,
    input logic         busy,
    input logic         done,
    input logic [4:0]   mode_q
);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R11
    load_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_we && !calc_we && !mode_we && !busy) |=> !done);

    // R3
    init0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && !busy && mode_data[3:0] == 4'h0) |=> (res_out == '0 && !flag_out));

    // R6
    init_flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && !busy && (mode_data[3:0] == 4'h1 || mode_data[3:0] == 4'h2)) |=> !flag_out);

    // R2
    busy_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_we) |=> $stable(mode_q));

    // R9
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (calc_we && !mode_we && !busy && mode_q[3:0] == 4'h3) |=> ($stable(res_out) && $stable(flag_out)));

    // R4
    load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_we && !calc_we && !mode_we && !busy && mode_q[3:0] != 4'h1 && mode_q[3:0] != 4'h2)
        |=> ($stable(res_out) && $stable(flag_out)));

endmodule

bind muldiv_copro copro_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_we   (mode_we),
    .mode_data (mode_data),
    .calc_we   (calc_we),
    .load_we   (load_we),
    .res_out   (res_out),
    .flag_out  (flag_out),
    .busy      (busy),
    .done      (done),
    .mode_q    (mode_q)
);

// File: tb/tb_muldiv_copro.sv
module tb_muldiv_copro;

    localparam int W          = 16;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_LAT    = W + 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_we = 1'b0;
    logic [7:0]   mode_data = '0;
    logic         calc_we = 1'b0;
    logic         load_we = 1'b0;
    logic [W-1:0] arg1 = '0;
    logic [W-1:0] arg2 = '0;
    logic [W-1:0] res_out;
    logic         flag_out;
    logic         busy;
    logic         done;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_acc  = '0;
    logic        m_flag = 1'b0;
    logic        m_half = 1'b0;

    muldiv_copro #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_data(mode_data),
        .calc_we(calc_we), .load_we(load_we), .arg1(arg1), .arg2(arg2),
        .res_out(res_out), .flag_out(flag_out), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [32:0] mac_ref(input logic [31:0] acc,
                                            input logic [15:0] a, input logic [15:0] b);
        logic [31:0] p;
        logic [31:0] s;
        logic        o;
        p = 32'($signed(a) * $signed(b));
        s = acc + p;
        o = (acc[31] == p[31]) && (s[31] != acc[31]);
        return {o, s};
    endfunction

    function automatic logic [31:0] div_ref(input logic [15:0] a, input logic [15:0] b);
        if (b == 16'h0) return {a, 16'hFFFF};
        return {16'(a % b), 16'(a / b)};
    endfunction

    function automatic logic [15:0] rnd_op();
        logic [2:0] k;
        k = 3'($urandom_range(0, 7));
        case (k)
            3'd0: return 16'h8000;
            3'd1: return 16'h7FFF;
            3'd2: return 16'hFFFF;
            default: return 16'($urandom);
        endcase
    endfunction

    task automatic set_mode(input logic [7:0] m);
        @(negedge clk);
        mode_we = 1'b1; mode_data = m;
        @(negedge clk);
        mode_we = 1'b0;
        m_half = m[4];
        if (m[3:0] == 4'h0) begin m_acc = '0; m_flag = 1'b0; end
        if (m[3:0] == 4'h1 || m[3:0] == 4'h2) m_flag = 1'b0;
    endtask

    task automatic do_load(input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        load_we = 1'b1; arg1 = a; arg2 = b;
        @(negedge clk);
        load_we = 1'b0;
    endtask

    task automatic do_calc(input logic [15:0] a, input logic [15:0] b,
                           output int lat, output logic busy1);
        @(negedge clk);
        calc_we = 1'b1; arg1 = a; arg2 = b;
        @(negedge clk);
        calc_we = 1'b0;
        lat = 1;
        busy1 = busy;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic read_acc(output logic [31:0] v);
        set_mode(8'h03);
        v[15:0] = res_out;
        set_mode(8'h13);
        v[31:16] = res_out;
    endtask

    task automatic check_out(input string req);
        logic [15:0] e;
        e = m_half ? m_acc[31:16] : m_acc[15:0];
        check(res_out == e, req, "res_out", 32'(res_out), 32'(e));
        check(flag_out == m_flag, req, "flag_out", 32'(flag_out), 32'(m_flag));
    endtask

    task automatic check_acc(input string req);
        logic [31:0] v;
        read_acc(v);
        check(v == m_acc, req, "register readback", v, m_acc);
        check(flag_out == m_flag, req, "flag after readback", 32'(flag_out), 32'(m_flag));
    endtask

    task automatic mac_step(input logic [15:0] a, input logic [15:0] b);
        int lat;
        logic b1;
        logic [32:0] r;
        r = mac_ref(m_acc, a, b);
        m_acc = r[31:0];
        m_flag = m_flag | r[32];
        do_calc(a, b, lat, b1);
        check(lat == 1, "R5", "mac latency", 32'(lat), 32'd1);
        check_out("R5_R6");
    endtask

    task automatic div_step(input logic [15:0] a, input logic [15:0] b);
        int lat;
        logic b1;
        m_acc = div_ref(a, b);
        m_flag = (b == 16'h0);
        do_calc(a, b, lat, b1);
        check(lat == DIV_LAT, "R7", "div latency", 32'(lat), 32'(DIV_LAT));
        check(b1 == 1'b1, "R11", "busy during division", 32'(b1), 32'd1);
        check_out(b == 16'h0 ? "R8" : "R7");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lat;
        logic b1;
        logic [31:0] v;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        // R1 reset state
        check(res_out == '0 && flag_out == 1'b0, "R1", "outputs after reset",
              {15'h0, flag_out, res_out}, 32'h0);
        check(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", {30'h0, busy, done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_acc("R1");

        // R4 32-bit preset, then R3 clear
        set_mode(8'h02);
        do_load(16'hDEAD, 16'hBEEF);
        m_acc = 32'hDEADBEEF;
        check_acc("R4");
        set_mode(8'h00);
        check_out("R3");
        check_acc("R3");

        // R4 16-bit preset sign-extends; load ignored in read mode
        set_mode(8'h01);
        do_load(16'h8001, 16'h1111);
        m_acc = 32'hFFFF8001;
        check_acc("R4");
        do_load(16'h1234, 16'h5678);
        check_acc("R4");

        // R6 overflow sticky, cleared by init write
        set_mode(8'h02);
        do_load(16'h7FFF, 16'hFFFF);
        m_acc = 32'h7FFFFFFF;
        set_mode(8'h07);
        mac_step(16'h0001, 16'h0001);
        check(flag_out == 1'b1, "R6", "overflow flag", 32'(flag_out), 32'd1);
        mac_step(16'h0000, 16'h0000);
        check_acc("R6");
        set_mode(8'h01);
        check(flag_out == 1'b0, "R6", "flag cleared by init", 32'(flag_out), 32'd0);

        // R5 extreme operands: two max positive products overflow
        set_mode(8'h00);
        set_mode(8'h07);
        mac_step(16'h8000, 16'h8000);
        mac_step(16'h8000, 16'h8000);
        check_acc("R5");

        // R5 random sequences with random preset and half select
        for (int s = 0; s < 20; s++) begin
            int kind;
            kind = $urandom_range(0, 2);
            if (kind == 0) begin
                set_mode(8'h00);
            end else if (kind == 1) begin
                logic [15:0] x;
                x = rnd_op();
                set_mode(8'h01);
                do_load(x, 16'h0);
                m_acc = {{16{x[15]}}, x};
            end else begin
                logic [15:0] x;
                logic [15:0] y;
                x = rnd_op(); y = rnd_op();
                set_mode(8'h02);
                do_load(x, y);
                m_acc = {x, y};
            end
            set_mode(($urandom_range(0, 1) != 0) ? 8'h17 : 8'h07);
            for (int k = 0; k < 6; k++) mac_step(rnd_op(), rnd_op());
            check_acc("R5");
        end

        // R7 / R8 division directed
        set_mode(8'h08);
        div_step(16'd100, 16'd7);
        div_step(16'hFFFF, 16'h0001);
        div_step(16'd5, 16'd9);
        div_step(16'h1234, 16'h0000);
        check_acc("R8");

        // R10 half select shows remainder
        set_mode(8'h08);
        div_step(16'd1000, 16'd33);
        set_mode(8'h18);
        check(res_out == 16'd10, "R10", "high half remainder", 32'(res_out), 32'd10);

        // R7 random division
        set_mode(8'h08);
        for (int k = 0; k < 30; k++) div_step(16'($urandom), 16'($urandom_range(0, 300)));

        // R11 mode write during division ignored
        @(negedge clk);
        calc_we = 1'b1; arg1 = 16'h4321; arg2 = 16'h0000;
        @(negedge clk);
        calc_we = 1'b0; mode_we = 1'b1; mode_data = 8'h00;
        @(negedge clk);
        mode_we = 1'b0;
        while (!done) @(negedge clk);
        m_acc = {16'h4321, 16'hFFFF}; m_flag = 1'b1; m_half = 1'b0;
        check_out("R11");
        @(negedge clk);
        div_step(16'd50, 16'd5);

        // R9 read mode and undefined op leave register unchanged
        set_mode(8'h13);
        do_calc(16'hAAAA, 16'h5555, lat, b1);
        check(lat == 1, "R9", "read latency", 32'(lat), 32'd1);
        check_out("R9");
        set_mode(8'h05);
        do_calc(16'h7FFF, 16'h7FFF, lat, b1);
        check(lat == 1, "R9", "undefined op latency", 32'(lat), 32'd1);
        check_acc("R9");

        // R2 upper mode bits ignored
        set_mode(8'hE8);
        div_step(16'd77, 16'd10);
        // R2 mode write wins over simultaneous calc
        set_mode(8'h07);
        @(negedge clk);
        mode_we = 1'b1; mode_data = 8'h03; calc_we = 1'b1; arg1 = 16'h7FFF; arg2 = 16'h7FFF;
        @(negedge clk);
        mode_we = 1'b0; calc_we = 1'b0; m_half = 1'b0;
        check(done == 1'b0, "R2", "no done on coincident writes", 32'(done), 32'd0);
        check_acc("R2");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule